// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the ALU of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) that never stalls and never inserts bubbles. Every cycle it looks at the instruction entering execute and compares its two source register indices with the destinations of older instructions that are still in flight. When a match exists, it replaces the operand read in decode with the newer result.

Decode reads the register file combinationally, and the file is only written at the end of write-back. A producer three instructions ahead of the consumer is therefore still missing from the value the consumer captured in decode. The unit keeps a one-entry history of the most recent write-back write to cover that case. A producer counts as a real register write only if its write-enable is high, its destination is not x0 and its result is not the all-ones marker that flags an invalid operation. Operand B of an immediate-format instruction always carries the immediate and is never replaced.

The unit has no state machine: its one stored item is the history entry. The selection logic is combinational, so the select codes and the resolved operands belong to the same cycle as the stage contents that produced them.

Top module: `opfwd_unit`

## Requirements
- R1: While reset is asserted the history entry is held empty. In the first cycle after reset is released, a source index equal to a write-back destination that was presented during reset is not forwarded: its select is 2'b00 and the operand equals the register-file input.
- R2: If the memory-stage producer is a valid write to the source register, the select is 2'b01 and the operand equals the memory-stage result, in the same cycle.
- R3: If the write-back producer is a valid write to the source register and the memory stage does not match, the select is 2'b10 and the operand equals the write-back result.
- R4: A valid write presented at write-back in one cycle is held for exactly one clock. In the next cycle, a source register that matches it and no younger producer gets select 2'b11 and the value of that write.
- R5: When several producers match, the youngest wins: memory stage first, then write-back, then the history entry.
- R6: A source index of 0 is never forwarded. Its select is 2'b00 and its operand is the register-file input, whatever the producers carry.
- R7: A producer whose write-enable is low, or whose result is 32'hFFFFFFFF, is ignored when matches are resolved. Such a write-back producer is also not forwarded through the history in the next cycle.
- R8: When the execute instruction is not register-register (b-is-register input low), operand B's select is 2'b00 and operand B equals its input (the immediate), even if its source-index field matches a producer.
- R9: Operand A and operand B (register-register form) follow the same rules independently. Each can take a different source in the same cycle.
- R10: A register-register sum built from the resolved operands of ADD x3,x1,x2, placed directly after ADDI x1=4 and ADDI x2=5, equals 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_rs1 | input | 5 | Source index of operand A of the instruction entering execute |
| ex_rs2 | input | 5 | Source index of operand B (index field of the instruction word) |
| ex_rf_a | input | 32 | Operand A as read in decode |
| ex_rf_b | input | 32 | Operand B as read in decode (register value or immediate) |
| ex_b_is_reg | input | 1 | High for register-register instructions; low means operand B is an immediate |
| mem_rd | input | 5 | Destination index of the instruction in the memory stage |
| mem_res | input | 32 | Result carried by the memory stage |
| mem_wen | input | 1 | Write-enable of the memory-stage instruction |
| wb_rd | input | 5 | Destination index of the instruction in write-back |
| wb_res | input | 32 | Result being written by write-back |
| wb_wen | input | 1 | Write-enable of the write-back instruction |
| fwd_sel_a | output | 2 | Operand A source: 00 none, 01 memory, 10 write-back, 11 history |
| fwd_sel_b | output | 2 | Operand B source, same coding |
| alu_opnd_a | output | 32 | Resolved operand A |
| alu_opnd_b | output | 32 | Resolved operand B |

## Verification
The select codes and resolved operands are combinational, so each is due in the same cycle as the stage contents that cause it. The bench drives inputs on the falling edge and samples the outputs one nanosecond later, before the next rising edge. A history effect becomes visible only in the cycle after the rising edge that captured the write-back contents. The bench model therefore updates its own history copy just after each rising edge and uses it for the checks in the following cycle. Random stimulus draws register indices from a narrow range so that matches, ties and the invalid marker occur often. Directed cycles cover the dependent add chain, the distance-three case, the x0 case and the immediate case.

// File: rtl/opfwd_pkg.sv
`timescale 1ns/1ps
package opfwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEM     = 2'b01,
        SRC_WB      = 2'b10,
        SRC_HIST    = 2'b11
    } opfwd_src_e;

    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/opfwd_qualify.sv
`timescale 1ns/1ps
// Decides whether an in-flight producer represents a real register write.
module opfwd_qualify #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  prod_rd,
    input  logic [DATA_W-1:0] prod_res,
    input  logic              prod_wen,
    output logic              prod_live
);
    localparam logic [DATA_W-1:0] BAD_MARK = {DATA_W{1'b1}};

    always_comb begin
        prod_live = prod_wen
                 && (prod_rd != '0)
                 && (prod_res != BAD_MARK);
    end
endmodule

// File: rtl/opfwd_history.sv
`timescale 1ns/1ps
// One-entry record of the write that write-back performed on the last clock.
module opfwd_history #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              wr_live,
    output logic [IDX_W-1:0]  old_idx,
    output logic [DATA_W-1:0] old_val,
    output logic              old_live
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            old_idx  <= '0;
            old_val  <= '0;
            old_live <= 1'b0;
        end else begin
            old_idx  <= wr_idx;
            old_val  <= wr_val;
            old_live <= wr_live;
        end
    end
endmodule

// File: rtl/opfwd_select.sv
`timescale 1ns/1ps
// Per-operand match and multiplexer, youngest producer first.
module opfwd_select
    import opfwd_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  src_idx,
    input  logic              may_fwd,
    input  logic [DATA_W-1:0] base_val,
    input  logic [IDX_W-1:0]  m_idx,
    input  logic [DATA_W-1:0] m_val,
    input  logic              m_live,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_val,
    input  logic              w_live,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [DATA_W-1:0] h_val,
    input  logic              h_live,
    output logic [1:0]        sel_code,
    output logic [DATA_W-1:0] sel_val
);
    logic        eligible;
    logic        hit_m;
    logic        hit_w;
    logic        hit_h;
    opfwd_src_e  src;

    always_comb begin
        eligible = may_fwd && (src_idx != '0);
        hit_m    = eligible && m_live && (m_idx == src_idx);
        hit_w    = eligible && w_live && (w_idx == src_idx);
        hit_h    = eligible && h_live && (h_idx == src_idx);
    end

    always_comb begin
        if (hit_m)      src = SRC_MEM;
        else if (hit_w) src = SRC_WB;
        else if (hit_h) src = SRC_HIST;
        else            src = SRC_REGFILE;
    end

    always_comb begin
        unique case (src)
            SRC_MEM:  sel_val = m_val;
            SRC_WB:   sel_val = w_val;
            SRC_HIST: sel_val = h_val;
            default:  sel_val = base_val;
        endcase
        sel_code = src;
    end
endmodule

// File: rtl/opfwd_unit.sv
`timescale 1ns/1ps
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ex_rs1,
    input  logic [IDX_W-1:0]  ex_rs2,
    input  logic [DATA_W-1:0] ex_rf_a,
    input  logic [DATA_W-1:0] ex_rf_b,
    input  logic              ex_b_is_reg,
    input  logic [IDX_W-1:0]  mem_rd,
    input  logic [DATA_W-1:0] mem_res,
    input  logic              mem_wen,
    input  logic [IDX_W-1:0]  wb_rd,
    input  logic [DATA_W-1:0] wb_res,
    input  logic              wb_wen,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic [DATA_W-1:0] alu_opnd_a,
    output logic [DATA_W-1:0] alu_opnd_b
);
    logic              mem_live;
    logic              wb_live;
    logic [IDX_W-1:0]  hist_idx;
    logic [DATA_W-1:0] hist_val;
    logic              hist_live;

    logic [IDX_W-1:0]  op_idx  [NUM_OPERANDS];
    logic              op_ok   [NUM_OPERANDS];
    logic [DATA_W-1:0] op_base [NUM_OPERANDS];
    logic [1:0]        op_sel  [NUM_OPERANDS];
    logic [DATA_W-1:0] op_out  [NUM_OPERANDS];

    opfwd_qualify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_q_mem (
        .prod_rd(mem_rd), .prod_res(mem_res), .prod_wen(mem_wen), .prod_live(mem_live)
    );

    opfwd_qualify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_q_wb (
        .prod_rd(wb_rd), .prod_res(wb_res), .prod_wen(wb_wen), .prod_live(wb_live)
    );

    opfwd_history #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_hist (
        .clk(clk), .rst_n(rst_n),
        .wr_idx(wb_rd), .wr_val(wb_res), .wr_live(wb_live),
        .old_idx(hist_idx), .old_val(hist_val), .old_live(hist_live)
    );

    always_comb begin
        op_idx[0]  = ex_rs1;
        op_ok[0]   = 1'b1;
        op_base[0] = ex_rf_a;
        op_idx[1]  = ex_rs2;
        op_ok[1]   = ex_b_is_reg;
        op_base[1] = ex_rf_b;
    end

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
        opfwd_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_sel (
            .src_idx(op_idx[g]), .may_fwd(op_ok[g]), .base_val(op_base[g]),
            .m_idx(mem_rd),   .m_val(mem_res),  .m_live(mem_live),
            .w_idx(wb_rd),    .w_val(wb_res),   .w_live(wb_live),
            .h_idx(hist_idx), .h_val(hist_val), .h_live(hist_live),
            .sel_code(op_sel[g]), .sel_val(op_out[g])
        );
    end

    always_comb begin
        fwd_sel_a  = op_sel[0];
        fwd_sel_b  = op_sel[1];
        alu_opnd_a = op_out[0];
        alu_opnd_b = op_out[1];
    end
endmodule

// File: rtl/opfwd_checker.sv
`timescale 1ns/1ps
module opfwd_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  ex_rs1,
    input logic [IDX_W-1:0]  ex_rs2,
    input logic [DATA_W-1:0] ex_rf_a,
    input logic [DATA_W-1:0] ex_rf_b,
    input logic              ex_b_is_reg,
    input logic [IDX_W-1:0]  mem_rd,
    input logic [DATA_W-1:0] mem_res,
    input logic              mem_wen,
    input logic [IDX_W-1:0]  wb_rd,
    input logic [DATA_W-1:0] wb_res,
    input logic              wb_wen,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic [DATA_W-1:0] alu_opnd_a,
    input logic [DATA_W-1:0] alu_opnd_b
);
    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    a_r2_mem_source: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == 2'b01) |-> (alu_opnd_a == mem_res && mem_rd == ex_rs1 && mem_wen && mem_res != ONES));

    a_r3_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == 2'b10) |-> (alu_opnd_a == wb_res && wb_rd == ex_rs1 && wb_wen));

    a_r4_hist_source: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a == 2'b11) |-> (alu_opnd_a == $past(wb_res) && $past(wb_rd) == ex_rs1 && $past(wb_wen)));

    a_r5_mem_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && mem_rd == ex_rs1 && ex_rs1 != '0 && mem_res != ONES) |-> (fwd_sel_a == 2'b01));

    a_r6_x0_local: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> (fwd_sel_a == 2'b00 && alu_opnd_a == ex_rf_a));

    a_r7_marker_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_b == 2'b01) |-> (mem_res != ONES && mem_wen));

    a_r8_immediate_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_b_is_reg) |-> (fwd_sel_b == 2'b00 && alu_opnd_b == ex_rf_b));
endmodule

bind opfwd_unit opfwd_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_opfwd_chk (
    .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b), .ex_b_is_reg(ex_b_is_reg),
    .mem_rd(mem_rd), .mem_res(mem_res), .mem_wen(mem_wen),
    .wb_rd(wb_rd), .wb_res(wb_res), .wb_wen(wb_wen),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
    .alu_opnd_a(alu_opnd_a), .alu_opnd_b(alu_opnd_b)
);

// File: tb/test_opfwd_unit.sv
`timescale 1ns/1ps
module test_opfwd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ex_rs1 = '0, ex_rs2 = '0, mem_rd = '0, wb_rd = '0;
    logic [31:0] ex_rf_a = '0, ex_rf_b = '0, mem_res = '0, wb_res = '0;
    logic        ex_b_is_reg = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]  fwd_sel_a, fwd_sel_b;
    logic [31:0] alu_opnd_a, alu_opnd_b;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench copy of the retired-write entry
    logic [4:0]  m_hidx = '0;
    logic [31:0] m_hval = '0;
    logic        m_hlive = 1'b0;

    always #2.5 clk = ~clk;

    opfwd_unit i_opfwd_unit (
        .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b), .ex_b_is_reg(ex_b_is_reg),
        .mem_rd(mem_rd), .mem_res(mem_res), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_res(wb_res), .wb_wen(wb_wen),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .alu_opnd_a(alu_opnd_a), .alu_opnd_b(alu_opnd_b)
    );

    function automatic bit live(input logic [4:0] rd, input logic [31:0] res, input logic wen);
        return wen && rd != 5'd0 && res != 32'hFFFF_FFFF;
    endfunction

    function automatic logic [1:0] ref_sel(input logic [4:0] rs, input logic ok);
        if (!ok || rs == 5'd0) return 2'b00;
        if (live(mem_rd, mem_res, mem_wen) && mem_rd == rs) return 2'b01;
        if (live(wb_rd, wb_res, wb_wen) && wb_rd == rs) return 2'b10;
        if (m_hlive && m_hidx == rs) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] base);
        case (s)
            2'b01:   return mem_res;
            2'b10:   return wb_res;
            2'b11:   return m_hval;
            default: return base;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] rs1, input logic [4:0] rs2,
                         input logic [31:0] rfa, input logic [31:0] rfb, input logic breg,
                         input logic [4:0] mrd, input logic [31:0] mres, input logic mwen,
                         input logic [4:0] wrd, input logic [31:0] wres, input logic wwen);
        @(negedge clk);
        ex_rs1 = rs1; ex_rs2 = rs2; ex_rf_a = rfa; ex_rf_b = rfb; ex_b_is_reg = breg;
        mem_rd = mrd; mem_res = mres; mem_wen = mwen;
        wb_rd = wrd;  wb_res = wres;  wb_wen = wwen;
        #1;
    endtask

    task automatic model_check(input string req);
        logic [1:0] sa, sb;
        sa = ref_sel(ex_rs1, 1'b1);
        sb = ref_sel(ex_rs2, ex_b_is_reg);
        check({req, " sel_a"}, {30'd0, fwd_sel_a}, {30'd0, sa});
        check({req, " opnd_a"}, alu_opnd_a, ref_val(sa, ex_rf_a));
        check({req, " sel_b"}, {30'd0, fwd_sel_b}, {30'd0, sb});
        check({req, " opnd_b"}, alu_opnd_b, ref_val(sb, ex_rf_b));
    endtask

    task automatic advance();
        @(posedge clk);
        #0.1;
        if (rst_n) begin
            m_hidx = wb_rd; m_hval = wb_res; m_hlive = live(wb_rd, wb_res, wb_wen);
        end else begin
            m_hidx = '0; m_hval = '0; m_hlive = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        if (!finished) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        // R1: write-back write presented during reset must not be remembered
        drive(5'd0, 5'd0, 32'd0, 32'd0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd5, 32'd16, 1'b1);
        repeat (3) advance();
        drive(5'd5, 5'd5, 32'd77, 32'd0, 1'b1, 5'd1, 32'd1, 1'b1, 5'd2, 32'd2, 1'b1);
        rst_n = 1'b1;
        #0.5;
        check("R1 sel_a after reset", {30'd0, fwd_sel_a}, 32'd0);
        check("R1 opnd_a after reset", alu_opnd_a, 32'd77);
        advance();

        // R8: ADDI x1=4 in execute, immediate field aliases a memory producer
        drive(5'd0, 5'd4, 32'd0, 32'd4, 1'b0, 5'd4, 32'd99, 1'b1, 5'd0, 32'd0, 1'b1);
        check("R8 sel_b immediate", {30'd0, fwd_sel_b}, 32'd0);
        check("R8 opnd_b immediate", alu_opnd_b, 32'd4);
        advance();
        // ADDI x2=5 in execute, ADDI x1 in memory
        drive(5'd0, 5'd1, 32'd0, 32'd5, 1'b0, 5'd1, 32'd4, 1'b1, 5'd4, 32'd99, 1'b1);
        check("R8 sel_b imm over rs2 match", {30'd0, fwd_sel_b}, 32'd0);
        advance();
        // ADD x3,x1,x2: x2 in memory, x1 in write-back, decode values stale
        drive(5'd1, 5'd2, 32'd0, 32'd0, 1'b1, 5'd2, 32'd5, 1'b1, 5'd1, 32'd4, 1'b1);
        check("R3 sel_a wb", {30'd0, fwd_sel_a}, 32'd2);
        check("R2 sel_b mem", {30'd0, fwd_sel_b}, 32'd1);
        check("R9 operands differ", {30'd0, fwd_sel_a ^ fwd_sel_b}, 32'd3);
        check("R10 ADD result", alu_opnd_a + alu_opnd_b, 32'd9);
        advance();

        // R4: distance three; x5=16 at write-back this cycle
        drive(5'd0, 5'd0, 32'd0, 32'd0, 1'b1, 5'd6, 32'd1, 1'b1, 5'd5, 32'd16, 1'b1);
        advance();
        drive(5'd5, 5'd3, 32'd0, 32'd0, 1'b1, 5'd6, 32'd1, 1'b1, 5'd7, 32'd2, 1'b1);
        check("R4 sel_a history", {30'd0, fwd_sel_a}, 32'd3);
        check("R4 opnd_a history", alu_opnd_a, 32'd16);
        advance();
        // history holds only one clock
        drive(5'd5, 5'd0, 32'd123, 32'd0, 1'b1, 5'd6, 32'd1, 1'b1, 5'd7, 32'd2, 1'b1);
        check("R4 history one clock", {30'd0, fwd_sel_a}, 32'd0);
        advance();

        // R6: x0 producers in every slot
        drive(5'd0, 5'd0, 32'd0, 32'd0, 1'b1, 5'd0, 32'd7, 1'b1, 5'd0, 32'd8, 1'b1);
        advance();
        drive(5'd0, 5'd0, 32'd0, 32'd0, 1'b1, 5'd0, 32'd7, 1'b1, 5'd0, 32'd8, 1'b1);
        check("R6 x0 sel_a", {30'd0, fwd_sel_a}, 32'd0);
        check("R6 x0 opnd_a", alu_opnd_a, 32'd0);
        check("R6 x0 opnd_b", alu_opnd_b, 32'd0);
        advance();

        // R5: all three match x3
        drive(5'd0, 5'd0, 32'd0, 32'd0, 1'b1, 5'd0, 32'd0, 1'b0, 5'd3, 32'd33, 1'b1);
        advance();
        drive(5'd3, 5'd3, 32'd0, 32'd0, 1'b1, 5'd3, 32'd11, 1'b1, 5'd3, 32'd22, 1'b1);
        check("R5 mem wins", alu_opnd_a, 32'd11);
        advance();
        drive(5'd3, 5'd3, 32'd0, 32'd0, 1'b1, 5'd0, 32'd0, 1'b0, 5'd3, 32'd44, 1'b1);
        check("R5 wb over history", alu_opnd_b, 32'd44);
        advance();

        // R7: invalid marker in memory, disabled write in write-back
        drive(5'd2, 5'd2, 32'd5, 32'd6, 1'b1, 5'd2, 32'hFFFF_FFFF, 1'b1, 5'd2, 32'd50, 1'b0);
        check("R7 marker and wen ignored a", alu_opnd_a, 32'd5);
        check("R7 marker and wen ignored b", {30'd0, fwd_sel_b}, 32'd0);
        advance();
        drive(5'd0, 5'd0, 32'd0, 32'd0, 1'b1, 5'd0, 32'd0, 1'b0, 5'd4, 32'hFFFF_FFFF, 1'b1);
        advance();
        drive(5'd4, 5'd4, 32'd9, 32'd9, 1'b1, 5'd0, 32'd0, 1'b0, 5'd0, 32'd0, 1'b0);
        check("R7 marker not in history", {30'd0, fwd_sel_a}, 32'd0);
        advance();

        // R2 R3 R4 R5 R6 R7 R8 R9: random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r1, r2;
            r1 = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
            r2 = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
            drive(5'($urandom % 4), 5'($urandom % 4), $urandom, $urandom, 1'($urandom % 4 != 0),
                  5'($urandom % 4), r1, 1'($urandom % 5 != 0),
                  5'($urandom % 4), r2, 1'($urandom % 5 != 0));
            model_check("R9 random");
            advance();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule